// File: doc/BRIEF.md
# Synchronous Transmit Idle Filler and Line Encoder

This block sits between a byte-oriented synchronous transmitter and the serial line. On every transmit clock enable it emits one bit. Within a message that bit comes from the upstream transmitter. Between messages it fills the line in one of two ways, chosen by a fill-mode input. The first way sends a steady run of ones and drops request-to-send. The second way sends a repeating pair of programmable sync characters and keeps request-to-send asserted.

The chosen bit then passes through a line coder that applies plain level coding or transition coding. In level coding a one is a high level. In transition coding a zero flips the line and a one holds it.

The upstream transmitter keeps `msg_active` high for as long as it has bits to send. It presents each bit on `msg_bit`. It advances to the next bit only after seeing `msg_take` high at a bit slot. The block finishes any sync pair it has started before it takes the first bit of a message. When the same enable cycle that would take a bit sees `msg_active` low, the message is over.

Top module: `sync_line_tx`

## Requirements
- R1: When `fill_sync`=0 and no message is in progress, each bit slot emits a one and `rts_out` is 0.
- R2: When `fill_sync`=1 and no message is in progress, the block repeatedly sends `sync_a` and then `sync_b`, each least significant bit first. From the first bit slot after reset, `rts_out` stays 1.
- R3: With `nrzi_sel`=0, after each bit slot `line_out` equals the emitted bit: 1 is high and 0 is low.
- R4: With `nrzi_sel`=1, an emitted one leaves `line_out` unchanged and an emitted zero inverts it. Idle ones therefore give a steady level.
- R5: After reset, `line_out`=1 and `rts_out`=0.
- R6: `msg_take` is high only in a cycle where `bit_en`=1, `msg_active`=1 and the block is in a message. `msg_bit` is registered at that edge and is on the line one clock later.
- R7: With `fill_sync`=0, a gap slot that sees `msg_active`=1 emits a one and raises `rts_out`. The message bits start at the next slot, so `rts_out` leads the first message bit by one bit time.
- R8: With `fill_sync`=0, the first slot of a message that sees `msg_active`=0 emits a one and drops `rts_out` at that same edge.
- R9: With `fill_sync`=1, a message starts only after bit 7 of `sync_b` has been sent. The slot that ends a message emits bit 0 of `sync_a`.
- R10: `line_out` and `rts_out` change only at clock edges where `bit_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Transmit bit-slot enable |
| msg_active | input | 1 | Upstream has message bits to send |
| msg_bit | input | 1 | Current message bit |
| msg_take | output | 1 | Message bit consumed at this edge |
| sync_a | input | SYNC_W | First fill sync character |
| sync_b | input | SYNC_W | Second fill sync character |
| fill_sync | input | 1 | 0: idle ones, RTS dropped; 1: sync pairs, RTS held |
| nrzi_sel | input | 1 | 0: level coding; 1: transition coding |
| line_out | output | 1 | Encoded serial line |
| rts_out | output | 1 | Request to send |

## Verification
Each bit slot is a single `bit_en` cycle. The new line level and RTS value appear one clock after that edge, and `msg_take` is valid in the same cycle as the enable. The driver pushes the predicted line and RTS values for each slot into a queue. The monitor samples one nanosecond after the enabling edge and pops one entry per enable. Between slots it checks that both outputs held. `msg_take` is compared during the enable cycle itself, before the edge that consumes the bit.

// File: rtl/sltx_pkg.sv
package sltx_pkg;
    typedef enum logic [1:0] {
        ST_GAP  = 2'd0,
        ST_MSG  = 2'd1,
        ST_FILL = 2'd2
    } tx_state_e;
endpackage

// File: rtl/sltx_pair_mux.sv
module sltx_pair_mux #(
    parameter int SYNC_W = 8,
    localparam int PAIR_W = 2 * SYNC_W,
    localparam int CW = $clog2(PAIR_W)
) (
    input  logic [SYNC_W-1:0] sync_a,
    input  logic [SYNC_W-1:0] sync_b,
    input  logic [CW-1:0]     idx,
    output logic              pair_bit
);
    logic [PAIR_W-1:0] pair_w;

    // Bit k of the pair word is the k-th bit on the line: sync_a LSB first, then sync_b.
    for (genvar k = 0; k < SYNC_W; k++) begin : g_pack
        assign pair_w[k]          = sync_a[k];
        assign pair_w[SYNC_W + k] = sync_b[k];
    end

    always_comb begin
        pair_bit = 1'b1;
        for (int k = 0; k < PAIR_W; k++) begin
            if (idx == CW'(k)) pair_bit = pair_w[k];
        end
    end
endmodule

// File: rtl/sltx_sequencer.sv
module sltx_sequencer
    import sltx_pkg::*;
#(
    parameter int SYNC_W = 8,
    localparam int PAIR_W = 2 * SYNC_W,
    localparam int CW = $clog2(PAIR_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          msg_active,
    input  logic          msg_bit,
    input  logic          fill_sync,
    input  logic          pair_bit,
    output logic [CW-1:0] pair_idx,
    output logic          tx_bit,
    output logic          msg_take,
    output logic          rts_q_o
);
    localparam logic [CW-1:0] LAST_IDX = CW'(PAIR_W - 1);

    typedef struct packed {
        tx_state_e     st;
        logic [CW-1:0] cnt;
        logic          rts;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        tx_bit   = 1'b1;
        msg_take = 1'b0;
        // The pair mux is indexed by the counter; position 0 when the fill starts from a message.
        pair_idx = (s_q.st == ST_FILL) ? s_q.cnt : '0;
        if (bit_en) begin
            unique case (s_q.st)
                ST_GAP: begin
                    tx_bit = 1'b1;
                    if (fill_sync) begin
                        s_d.st  = ST_FILL;
                        s_d.cnt = '0;
                        s_d.rts = 1'b1;
                    end else if (msg_active) begin
                        s_d.st  = ST_MSG;
                        s_d.rts = 1'b1;
                    end else begin
                        s_d.rts = 1'b0;
                    end
                end
                ST_MSG: begin
                    if (msg_active) begin
                        tx_bit   = msg_bit;
                        msg_take = 1'b1;
                        s_d.rts  = 1'b1;
                    end else if (fill_sync) begin
                        tx_bit  = pair_bit;
                        s_d.st  = ST_FILL;
                        s_d.cnt = CW'(1);
                        s_d.rts = 1'b1;
                    end else begin
                        tx_bit  = 1'b1;
                        s_d.st  = ST_GAP;
                        s_d.rts = 1'b0;
                    end
                end
                ST_FILL: begin
                    tx_bit  = pair_bit;
                    s_d.rts = 1'b1;
                    if (s_q.cnt == LAST_IDX) begin
                        s_d.cnt = '0;
                        if (msg_active)      s_d.st = ST_MSG;
                        else if (!fill_sync) s_d.st = ST_GAP;
                    end else begin
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
                default: begin
                    s_d.st  = ST_GAP;
                    s_d.cnt = '0;
                    s_d.rts = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st  <= ST_GAP;
            s_q.cnt <= '0;
            s_q.rts <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rts_q_o = s_q.rts;

    // R6: a bit is taken only in an enabled slot while the message is live
    a_r6_take_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        msg_take |-> (bit_en && msg_active && s_q.st == ST_MSG));

    // R9: no message may start before the pair is complete
    a_r9_pair_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && s_q.st == ST_FILL && s_q.cnt != LAST_IDX) |=> (s_q.st == ST_FILL));

    // R2: RTS is held while filling with sync characters
    a_r2_rts_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_FILL) |-> s_q.rts);

    // R7: a message request in a ones gap raises RTS and enters the message one slot early
    a_r7_lead_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && s_q.st == ST_GAP && msg_active && !fill_sync) |=> (s_q.rts && s_q.st == ST_MSG));

    // R8: the end of a message in ones mode drops RTS
    a_r8_rts_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && s_q.st == ST_MSG && !msg_active && !fill_sync) |=> !s_q.rts);
endmodule

// File: rtl/sltx_line_coder.sv
module sltx_line_coder (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic nrzi_sel,
    input  logic bit_in,
    output logic line_q_o
);
    logic line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (bit_en) begin
            if (nrzi_sel) line_d = bit_in ? line_q : ~line_q;
            else          line_d = bit_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line_d;
    end

    assign line_q_o = line_q;

    // R3: level coding places the bit on the line
    a_r3_level: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !nrzi_sel) |=> (line_q == $past(bit_in)));

    // R4: in transition coding a one holds the level
    a_r4_one_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && nrzi_sel && bit_in) |=> $stable(line_q));

    // R4: in transition coding a zero flips the level
    a_r4_zero_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && nrzi_sel && !bit_in) |=> (line_q != $past(line_q)));

    // R10: the line only moves on enabled slots
    a_r10_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(line_q));
endmodule

// File: rtl/sync_line_tx.sv
module sync_line_tx #(
    parameter int SYNC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              msg_active,
    input  logic              msg_bit,
    output logic              msg_take,
    input  logic [SYNC_W-1:0] sync_a,
    input  logic [SYNC_W-1:0] sync_b,
    input  logic              fill_sync,
    input  logic              nrzi_sel,
    output logic              line_out,
    output logic              rts_out
);
    localparam int CW = $clog2(2 * SYNC_W);

    logic [CW-1:0] pair_idx;
    logic          pair_bit;
    logic          tx_bit;

    sltx_pair_mux #(.SYNC_W(SYNC_W)) u_pair (
        .sync_a   (sync_a),
        .sync_b   (sync_b),
        .idx      (pair_idx),
        .pair_bit (pair_bit)
    );

    sltx_sequencer #(.SYNC_W(SYNC_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .msg_active (msg_active),
        .msg_bit    (msg_bit),
        .fill_sync  (fill_sync),
        .pair_bit   (pair_bit),
        .pair_idx   (pair_idx),
        .tx_bit     (tx_bit),
        .msg_take   (msg_take),
        .rts_q_o    (rts_out)
    );

    sltx_line_coder u_coder (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .nrzi_sel (nrzi_sel),
        .bit_in   (tx_bit),
        .line_q_o (line_out)
    );

    // R1: with RTS low in steady level coding, the line rests at one
    a_r1_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts_out && !nrzi_sel && $stable(nrzi_sel)) |-> line_out);

    // R10: RTS only moves on enabled slots
    a_r10_rts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(rts_out));
endmodule

// File: tb/test_sync_line_tx.sv
module test_sync_line_tx;
    localparam int SYNC_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic msg_active = 1'b0;
    logic msg_bit = 1'b0;
    logic msg_take;
    logic [SYNC_W-1:0] sync_a = 8'h96;
    logic [SYNC_W-1:0] sync_b = 8'h3C;
    logic fill_sync = 1'b0;
    logic nrzi_sel = 1'b0;
    logic line_out;
    logic rts_out;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    sync_line_tx #(.SYNC_W(SYNC_W)) i_sync_line_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .msg_active (msg_active),
        .msg_bit    (msg_bit),
        .msg_take   (msg_take),
        .sync_a     (sync_a),
        .sync_b     (sync_b),
        .fill_sync  (fill_sync),
        .nrzi_sel   (nrzi_sel),
        .line_out   (line_out),
        .rts_out    (rts_out)
    );

    // reference state built from the requirements
    int   m_st;   // 0 gap, 1 message, 2 filling
    int   m_cnt;
    logic m_line;
    logic m_rts;
    logic [1:0] exp_q[$];
    logic last_line, last_rts;
    logic mon_on = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model(input logic act, input logic b, output logic take);
        logic [15:0] pair;
        logic e;
        pair = {sync_b, sync_a};
        take = 1'b0;
        e = 1'b1;
        case (m_st)
            0: begin
                e = 1'b1;
                if (fill_sync) begin m_st = 2; m_cnt = 0; m_rts = 1'b1; end
                else if (act) begin m_st = 1; m_rts = 1'b1; end
                else m_rts = 1'b0;
            end
            1: begin
                if (act) begin e = b; take = 1'b1; m_rts = 1'b1; end
                else if (fill_sync) begin e = pair[0]; m_st = 2; m_cnt = 1; m_rts = 1'b1; end
                else begin e = 1'b1; m_st = 0; m_rts = 1'b0; end
            end
            default: begin
                e = pair[m_cnt];
                m_rts = 1'b1;
                if (m_cnt == 15) begin
                    m_cnt = 0;
                    if (act) m_st = 1;
                    else if (!fill_sync) m_st = 0;
                end else m_cnt++;
            end
        endcase
        m_line = nrzi_sel ? (e ? m_line : ~m_line) : e;
    endtask

    task automatic slot(input logic act, input logic b, output logic took);
        @(negedge clk);
        msg_active = act;
        msg_bit = b;
        bit_en = 1'b1;
        model(act, b, took);
        exp_q.push_back({m_line, m_rts});
        #1;
        // R6: take strobe due in the enable cycle itself
        check(msg_take == took, "R6", "msg_take", msg_take, took);
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic do_reset(input logic fs, input logic nz);
        @(negedge clk);
        mon_on = 1'b0;
        rst_n = 1'b0;
        bit_en = 1'b0;
        msg_active = 1'b0;
        fill_sync = fs;
        nrzi_sel = nz;
        exp_q.delete();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_st = 0; m_cnt = 0; m_line = 1'b1; m_rts = 1'b0;
        // R5: reset levels
        check(line_out == 1'b1, "R5", "line after reset", line_out, 1);
        check(rts_out == 1'b0, "R5", "rts after reset", rts_out, 0);
        last_line = line_out;
        last_rts = rts_out;
        mon_on = 1'b1;
    endtask

    task automatic idle(input int n);
        logic t;
        for (int i = 0; i < n; i++) slot(1'b0, 1'b0, t);
    endtask

    task automatic send(input logic [31:0] pat, input int n);
        logic t;
        int i;
        i = 0;
        while (i < n) begin
            if (i == 0 && m_st == 1 && !fill_sync) begin
                // R7: RTS already up one slot before the first message bit
                check(rts_out == 1'b1, "R7", "rts lead", rts_out, 1);
            end
            slot(1'b1, pat[i], t);
            if (t) i++;
        end
    endtask

    // monitor: pops one prediction per enabled slot, checks hold otherwise
    always begin
        logic en_s;
        logic [1:0] e;
        @(posedge clk);
        en_s = bit_en;
        #1;
        if (mon_on && rst_n) begin
            if (en_s) begin
                e = exp_q.pop_front();
                // line: R3 level coding / R4 transition coding; also covers R9 sync order
                check(line_out == e[1], nrzi_sel ? "R4" : "R3", "line", line_out, e[1]);
                // rts: R1 ones gaps / R2 sync fill; R8 drop at message end
                check(rts_out == e[0], fill_sync ? "R2" : "R1", "rts", rts_out, e[0]);
            end else begin
                check(line_out == last_line, "R10", "line hold", line_out, last_line);
                check(rts_out == last_rts, "R10", "rts hold", rts_out, last_rts);
            end
            last_line = line_out;
            last_rts = rts_out;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic t;
        for (int nz = 0; nz < 2; nz++) begin
            // ones-fill mode
            do_reset(1'b0, nz[0]);
            idle(4);
            send(32'h0000_2D6B, 14);
            slot(1'b0, 1'b0, t);
            @(negedge clk);
            // R8: RTS falls at the first slot without a message
            check(rts_out == 1'b0, "R8", "rts after end", rts_out, 0);
            idle(5);
            send(32'h0000_00F0, 8);
            idle(3);

            // sync-fill mode
            do_reset(1'b1, nz[0]);
            idle(5);
            send(32'h0000_A55A, 16);
            slot(1'b0, 1'b0, t);
            @(negedge clk);
            if (!nz[0]) begin
                // R9: the fill restarts at bit 0 of the first sync character
                check(line_out == sync_a[0], "R9", "first fill bit", line_out, sync_a[0]);
            end
            idle(21);
            send(32'h0000_0013, 6);
            idle(18);
        end
        @(negedge clk);
        @(negedge clk);
        mon_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule